// File: doc/BRIEF.md
# Fractional baud-rate tick generator

This block turns the system clock into two strobes for a serial port. The first is an oversampling tick at 8 or 16 times the bit rate. The second is a bit-rate tick taken from every 8th or 16th oversampling tick. The period of the oversampling tick comes from a divisor that has a 16-bit integer part and a 6-bit fractional part, so it can be set in 1/64 steps. Each oversampling period lasts either the integer count of clocks or one clock more. A 6-bit phase accumulator chooses between the two, so that the average period over 64 periods is exactly integer + fraction/64.

Software writes the integer and fraction values to separate staging ports. These writes do nothing to the running ticks. A later write to the line-control port copies the staged integer, the staged fraction and the new line-control byte into one active configuration register in a single clock. The same write restarts the period counter, the phase accumulator and the bit-tick counter, so the new rate begins on a clean boundary. The high-speed select picks divide-by-8. Smart-card mode overrides it and keeps divide-by-16.

Top module: `fbaud_gen`

## Requirements
- R1: After synchronous reset, `os_tick` and `bit_tick` stay low and `line_cfg` is 0, because the active integer part is 0.
- R2: Writes to the integer or fraction staging ports do not change `line_cfg` or the tick timing until a later line-control write.
- R3: A line-control write loads the staged integer, the staged fraction and the written byte into the active register at once. `line_cfg` shows the byte from the next cycle on.
- R4: The four update orders (integer, fraction, line; fraction, integer, line; integer, line; fraction, line) each give the same active configuration. The last two keep the other part's earlier staged value.
- R5: With active integer N ≥ 1 and fraction F, each oversampling period lasts N clocks, or N+1 clocks when adding F to the 6-bit accumulator carries out of bit 5. Any 64 consecutive periods total 64·N+F clocks.
- R6: A commit clears the counter and the accumulator. With N ≥ 1 and any F, the first `os_tick` after the commit is high in the N-th cycle after the commit edge, and the first period never receives the extra clock.
- R7: When the active integer part is 0, `os_tick` and `bit_tick` stay low.
- R8: With `hs_sel` = 0, `bit_tick` is high together with every 16th `os_tick` counted from the commit, starting with the 16th. It is never high without `os_tick`.
- R9: With `hs_sel` = 1 and `smart_sel` = 0, `bit_tick` is high with every 8th `os_tick`, starting with the 8th.
- R10: With `smart_sel` = 1, the divide stays 16 whatever the value of `hs_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_wr_en | input | 1 | Write strobe for the integer staging register |
| int_wr_data | input | 16 | Integer part of the divisor |
| frac_wr_en | input | 1 | Write strobe for the fraction staging register |
| frac_wr_data | input | 6 | Fraction part of the divisor, in 1/64 units |
| lcr_wr_en | input | 1 | Line-control write; commits the staged divisor |
| lcr_wr_data | input | 8 | Line-control byte |
| hs_sel | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| smart_sel | input | 1 | Smart-card mode; forces 16x |
| line_cfg | output | 8 | Committed line-control byte |
| os_tick | output | 1 | Oversampling tick, one cycle per period |
| bit_tick | output | 1 | Bit-rate tick, coincides with an os_tick |

## Verification
The bench uses the default widths (16-bit integer, 6-bit fraction) but keeps integer values between 1 and 4. Each run of 65 periods therefore covers a full 64-step accumulator cycle in a few hundred clocks. A sweep over several fractions, including 0, 1, 32 and 63, checks every tick position against a period schedule computed in the bench. It also checks the 64·N+F period sum and every bit-tick position for all three divide settings. Small integers also make the N=1 edge and the zero-integer idle case cheap to check, along with each of the four commit orders.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;

    localparam int OS_LO = 8;
    localparam int OS_HI = 16;
    localparam int OS_CW = $clog2(OS_HI);

    typedef enum logic {
        OS_X16 = 1'b0,
        OS_X8  = 1'b1
    } os_mode_e;

    // Smart-card mode wins over the high-speed select.
    function automatic os_mode_e pick_mode(input logic hs, input logic smart);
        return (hs && !smart) ? OS_X8 : OS_X16;
    endfunction

    function automatic logic [OS_CW-1:0] mode_last(input os_mode_e m);
        return (m == OS_X8) ? OS_CW'(OS_LO - 1) : OS_CW'(OS_HI - 1);
    endfunction

endpackage

// File: rtl/fbaud_stage.sv
module fbaud_stage #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int LCR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_wr_en,
    input  logic [INT_W-1:0]  int_wr_data,
    input  logic              frac_wr_en,
    input  logic [FRAC_W-1:0] frac_wr_data,
    input  logic              lcr_wr_en,
    input  logic [LCR_W-1:0]  lcr_wr_data,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic [LCR_W-1:0]  act_lcr
);
    typedef struct packed {
        logic [INT_W-1:0]  div_int;
        logic [FRAC_W-1:0] div_frac;
        logic [LCR_W-1:0]  lcr;
    } cfg_t;

    logic [INT_W-1:0]  stg_int;
    logic [FRAC_W-1:0] stg_frac;
    cfg_t              active_q;
    cfg_t              active_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_int  <= '0;
            stg_frac <= '0;
        end else begin
            if (int_wr_en)  stg_int  <= int_wr_data;
            if (frac_wr_en) stg_frac <= frac_wr_data;
        end
    end

    // A staging write in the same cycle as the commit is forwarded.
    always_comb begin
        active_d          = active_q;
        active_d.div_int  = int_wr_en  ? int_wr_data  : stg_int;
        active_d.div_frac = frac_wr_en ? frac_wr_data : stg_frac;
        active_d.lcr      = lcr_wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)            active_q <= '0;
        else if (lcr_wr_en) active_q <= active_d;
    end

    assign act_int  = active_q.div_int;
    assign act_frac = active_q.div_frac;
    assign act_lcr  = active_q.lcr;
endmodule

// File: rtl/fbaud_frac_div.sv
module fbaud_frac_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              os_tick
);
    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic              stretch;
    logic [INT_W:0]    last_cnt;
    logic              running;

    assign acc_sum  = {1'b0, acc} + {1'b0, div_frac};
    assign stretch  = acc_sum[FRAC_W];
    assign last_cnt = {1'b0, div_int} - (INT_W+1)'(1) + (INT_W+1)'(stretch);
    assign running  = (div_int != '0);
    assign os_tick  = running && ({1'b0, cnt} == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart || !running) begin
            cnt <= '0;
            acc <= '0;
        end else if (os_tick) begin
            cnt <= '0;
            acc <= acc_sum[FRAC_W-1:0];
        end else begin
            cnt <= cnt + INT_W'(1);
        end
    end
endmodule

// File: rtl/fbaud_bit_div.sv
module fbaud_bit_div
    import fbaud_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     os_tick,
    input  os_mode_e mode,
    output logic     bit_tick
);
    logic [OS_CW-1:0] ocnt;
    logic [OS_CW-1:0] last;

    assign last     = mode_last(mode);
    // Using >= keeps the counter safe when the mode shrinks mid-count.
    assign bit_tick = os_tick && (ocnt >= last);

    always_ff @(posedge clk) begin
        if (rst || restart)  ocnt <= '0;
        else if (bit_tick)   ocnt <= '0;
        else if (os_tick)    ocnt <= ocnt + OS_CW'(1);
    end
endmodule

// File: rtl/fbaud_gen.sv
module fbaud_gen
    import fbaud_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int LCR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_wr_en,
    input  logic [INT_W-1:0]  int_wr_data,
    input  logic              frac_wr_en,
    input  logic [FRAC_W-1:0] frac_wr_data,
    input  logic              lcr_wr_en,
    input  logic [LCR_W-1:0]  lcr_wr_data,
    input  logic              hs_sel,
    input  logic              smart_sel,
    output logic [LCR_W-1:0]  line_cfg,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    os_mode_e          mode;

    assign mode = pick_mode(hs_sel, smart_sel);

    fbaud_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LCR_W(LCR_W)) u_stage (
        .clk          (clk),
        .rst          (rst),
        .int_wr_en    (int_wr_en),
        .int_wr_data  (int_wr_data),
        .frac_wr_en   (frac_wr_en),
        .frac_wr_data (frac_wr_data),
        .lcr_wr_en    (lcr_wr_en),
        .lcr_wr_data  (lcr_wr_data),
        .act_int      (act_int),
        .act_frac     (act_frac),
        .act_lcr      (line_cfg)
    );

    fbaud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac (
        .clk      (clk),
        .rst      (rst),
        .restart  (lcr_wr_en),
        .div_int  (act_int),
        .div_frac (act_frac),
        .os_tick  (os_tick)
    );

    fbaud_bit_div u_bit (
        .clk      (clk),
        .rst      (rst),
        .restart  (lcr_wr_en),
        .os_tick  (os_tick),
        .mode     (mode),
        .bit_tick (bit_tick)
    );
endmodule

// File: rtl/fbaud_gen_chk.sv
module fbaud_gen_chk #(
    parameter int INT_W = 16,
    parameter int LCR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lcr_wr_en,
    input logic [LCR_W-1:0] lcr_wr_data,
    input logic [LCR_W-1:0] line_cfg,
    input logic [INT_W-1:0] act_int,
    input logic             os_tick,
    input logic             bit_tick
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!os_tick && !bit_tick && line_cfg == '0));

    assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        !lcr_wr_en |=> $stable(line_cfg));

    assert_commit_cfg_R3: assert property (@(posedge clk) disable iff (rst)
        lcr_wr_en |=> line_cfg == $past(lcr_wr_data));

    assert_clean_restart_R6: assert property (@(posedge clk) disable iff (rst)
        lcr_wr_en |=> (!os_tick || act_int == INT_W'(1)));

    assert_zero_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (act_int == '0) |-> !os_tick);

    assert_bit_in_os_R8: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);
endmodule

bind fbaud_gen fbaud_gen_chk #(.INT_W(INT_W), .LCR_W(LCR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lcr_wr_en   (lcr_wr_en),
    .lcr_wr_data (lcr_wr_data),
    .line_cfg    (line_cfg),
    .act_int     (act_int),
    .os_tick     (os_tick),
    .bit_tick    (bit_tick)
);

// File: tb/fbaud_gen_tb.sv
module fbaud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        int_wr_en = 1'b0;
    logic [15:0] int_wr_data = '0;
    logic        frac_wr_en = 1'b0;
    logic [5:0]  frac_wr_data = '0;
    logic        lcr_wr_en = 1'b0;
    logic [7:0]  lcr_wr_data = '0;
    logic        hs_sel = 1'b0;
    logic        smart_sel = 1'b0;
    logic [7:0]  line_cfg;
    logic        os_tick;
    logic        bit_tick;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    fbaud_gen dut_i (
        .clk(clk), .rst(rst),
        .int_wr_en(int_wr_en), .int_wr_data(int_wr_data),
        .frac_wr_en(frac_wr_en), .frac_wr_data(frac_wr_data),
        .lcr_wr_en(lcr_wr_en), .lcr_wr_data(lcr_wr_data),
        .hs_sel(hs_sel), .smart_sel(smart_sel),
        .line_cfg(line_cfg), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_int(input int v);
        @(negedge clk); int_wr_en = 1'b1; int_wr_data = 16'(v);
        @(negedge clk); int_wr_en = 1'b0;
    endtask

    task automatic put_frac(input int v);
        @(negedge clk); frac_wr_en = 1'b1; frac_wr_data = 6'(v);
        @(negedge clk); frac_wr_en = 1'b0;
    endtask

    // Ends on the first negedge after the commit edge (cycle 0).
    task automatic put_lcr(input int v);
        @(negedge clk); lcr_wr_en = 1'b1; lcr_wr_data = 8'(v);
        @(negedge clk); lcr_wr_en = 1'b0;
    endtask

    // Compare every cycle against the arithmetic schedule (R5, R6, R8-R10).
    task automatic run_sched(input int n, input int f, input int fac,
                             input int periods, input string req);
        int acc = 0;
        int next_t = n - 1;
        int ticks = 0;
        int c = 0;
        int bad = 0;
        int first_c = -1;
        int bad_c = -1;
        int t0 = 0;
        int t64 = 0;
        bit exp_os;
        bit exp_bit;
        while (ticks < periods && c < periods * (n + 1) + 4) begin
            exp_os  = (c == next_t);
            exp_bit = exp_os && ((ticks % fac) == fac - 1);
            if (os_tick !== exp_os || bit_tick !== exp_bit) begin
                bad++;
                if (first_c < 0) begin first_c = c; bad_c = {os_tick, bit_tick}; end
            end
            if (exp_os) begin
                if (ticks == 0)  t0 = c;
                if (ticks == 64) t64 = c;
                ticks++;
                acc = (acc + f) % 64;
                next_t += n + (((acc + f) >= 64) ? 1 : 0);
            end
            c++;
            @(negedge clk);
        end
        check(bad == 0, req, bad_c, first_c);
        if (periods > 64)
            check(t64 - t0 == 64 * n + f, "R5 sum of 64 periods", t64 - t0, 64 * n + f);
    endtask

    task automatic quiet_for(input int cycles, input string req);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            if (os_tick || bit_tick) hits++;
            @(negedge clk);
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin : watchdog
        #(10 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(line_cfg == 8'h00, "R1 line_cfg after reset", line_cfg, 0);
        quiet_for(40, "R1 no ticks after reset");

        // R5/R6/R8/R9: sweep integer and fraction, alternate hs.
        for (int n = 1; n <= 4; n++) begin
            for (int k = 0; k < 7; k++) begin
                int fr;
                int lv;
                fr = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 7 : (k == 3) ? 21 :
                     (k == 4) ? 32 : (k == 5) ? 45 : 63;
                lv = (n * 16 + k) & 8'hFF;
                hs_sel = k[0];
                smart_sel = 1'b0;
                put_int(n);
                put_frac(fr);
                put_lcr(lv);
                check(line_cfg == 8'(lv), "R3 line_cfg after commit", line_cfg, lv);
                run_sched(n, fr, k[0] ? 8 : 16, 66,
                          k[0] ? "R9 R5 R6 schedule x8" : "R8 R5 R6 schedule x16");
            end
        end

        // R10: smart-card overrides high-speed.
        hs_sel = 1'b1; smart_sel = 1'b1;
        put_int(2); put_frac(13); put_lcr(8'h5A);
        run_sched(2, 13, 16, 66, "R10 smart forces x16");
        hs_sel = 1'b0; smart_sel = 1'b0;

        // R2: staged writes have no effect before a commit.
        put_int(3); put_frac(0); put_lcr(8'h33);
        int_wr_en = 1'b1; int_wr_data = 16'd7; frac_wr_en = 1'b1; frac_wr_data = 6'd5;
        @(negedge clk);
        int_wr_en = 1'b0; frac_wr_en = 1'b0;
        check(line_cfg == 8'h33, "R2 line_cfg held", line_cfg, 8'h33);
        // Old rate N=3,F=0: one tick every 3 cycles from here.
        begin
            int cnt_os = 0;
            for (int i = 0; i < 60; i++) begin
                if (os_tick) cnt_os++;
                @(negedge clk);
            end
            check(cnt_os == 20, "R2 old rate kept", cnt_os, 20);
        end

        // R4: four update orders.
        put_int(3); put_frac(9); put_lcr(8'h01);
        run_sched(3, 9, 16, 66, "R4 order int,frac,lcr");
        put_frac(50); put_int(2); put_lcr(8'h02);
        run_sched(2, 50, 16, 66, "R4 order frac,int,lcr");
        put_int(4); put_lcr(8'h03);
        run_sched(4, 50, 16, 66, "R4 order int,lcr keeps frac");
        put_frac(3); put_lcr(8'h04);
        run_sched(4, 3, 16, 66, "R4 order frac,lcr keeps int");
        check(line_cfg == 8'h04, "R4 line_cfg", line_cfg, 4);

        // R3: same-cycle stage write and commit.
        @(negedge clk);
        int_wr_en = 1'b1; int_wr_data = 16'd1; frac_wr_en = 1'b1; frac_wr_data = 6'd0;
        lcr_wr_en = 1'b1; lcr_wr_data = 8'hA5;
        @(negedge clk);
        int_wr_en = 1'b0; frac_wr_en = 1'b0; lcr_wr_en = 1'b0;
        run_sched(1, 0, 16, 40, "R3 R6 same-cycle commit N=1");

        // R7: zero integer part idles.
        put_int(0); put_frac(17); put_lcr(8'hC3);
        quiet_for(200, "R7 zero integer no ticks");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule